// File: doc/BRIEF.md
# Ethernet Transmit FIFO Framer

This block sits on the transmit side of an Ethernet MAC. Software fills a single-frame store with whole 32-bit words. The first two bytes of that byte stream carry the frame length, and the payload bytes follow them. Software then raises a transmit request. The block reads the length, walks the stored bytes in order and hands them one at a time to the MAC over a valid/ready byte interface. It flags the final byte with an end-of-frame marker.

When the pad control is set, a frame whose stated length is under the Ethernet minimum of 60 bytes is stretched to 60 bytes with zero bytes. Any byte position that no write ever covered is also sent as zero. Old store contents therefore never reach the wire.

When the frame is complete, the store empties and a one-cycle done pulse fires. Writes that cannot be taken, because a frame is in flight or the store is full, are dropped and raise a sticky overflow flag.

Top module: `txq_framer`

## Requirements
- R1: After reset, `busy`, `overflow`, `frame_done`, `m_valid` and `m_last` are all low.
- R2: Each accepted write appends one 32-bit word. Byte lane k (bits 8k+7:8k) of the n-th word written is stream byte 4n+k. Stream bytes 0 (low) and 1 (high) form the little-endian frame length, and payload byte i is stream byte i+2.
- R3: A `tx_req` pulse starts a frame only when the block is idle and at least one word is stored. A request with an empty store, or one made while a frame is in flight, has no effect.
- R4: Payload bytes leave in stream order, one for each cycle in which both `m_valid` and `m_ready` are high. `m_data` holds steady while `m_valid` is high and `m_ready` is low.
- R5: `m_last` is high only on the final byte of a frame. Byte lanes of the last word that lie beyond the frame are never sent.
- R6: `pad_en` is sampled when the frame starts. If it is set and the stated length is below 60, the frame is 60 bytes long, and every byte after the payload is 0x00.
- R7: If `pad_en` is clear at the start, exactly the stated length in bytes is sent. A stated length of 0 sends no bytes and completes at once.
- R8: A payload byte whose stream position was never covered by a write in this frame is sent as 0x00.
- R9: `busy` is high from the cycle after the start until the last byte is accepted. `frame_done` pulses for exactly one cycle, in the cycle after that acceptance. The store is then empty for the next frame.
- R10: A write while busy, or while the store is full, is dropped and sets `overflow`. The flag stays set until the next frame start that has no rejected write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | 32 | Word to append to the store |
| tx_req | input | 1 | Request to transmit the stored frame |
| pad_en | input | 1 | Pad short frames to 60 bytes with zeros |
| busy | output | 1 | A frame is being streamed |
| overflow | output | 1 | Sticky: a write was dropped |
| frame_done | output | 1 | One-cycle pulse after the final byte is taken |
| m_valid | output | 1 | Byte offered to the MAC |
| m_ready | input | 1 | MAC takes the offered byte |
| m_data | output | 8 | Byte value |
| m_last | output | 1 | Offered byte ends the frame |

## Verification
The embedded properties take for granted that every input is a known value from the first released clock onward and that reset is held for at least one edge. They place no rule on `m_ready`, which may drop at any time. The stall-hold and zero-pad properties also rely on the store never changing under a frame in flight, and the block enforces this itself by locking writes.

The stimulus changes every input half a period away from the sampling edge. It drives `m_ready` from a pseudo-random sequence so that stalls land on every byte position. It writes only while idle, except for deliberate probes that test rejection.

// File: rtl/txq_pkg.sv
// Shared constants and types for the transmit FIFO framer.
// Assumes a 16-bit in-band length prefix and a 32-bit word write port.
package txq_pkg;
    localparam int LEN_W = 16;          // width of the in-band length prefix
    localparam int CW    = LEN_W + 1;   // byte counter width, covers padded length too
    localparam int LANES = 4;           // bytes per written word

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } seq_state_t;
endpackage

// File: rtl/txq_store.sv
// Single-frame word store with append pointer and overflow flag.
// Accepts whole words while unlocked and not full; a flush empties it.
// Assumes flush is only raised while lock is high or at a frame start.
module txq_store
    import txq_pkg::*;
#(
    parameter  int DEPTH_BYTES = 2048,
    localparam int WORDS = DEPTH_BYTES / LANES,
    localparam int AW    = $clog2(WORDS),
    localparam int PW    = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             lock,
    input  logic             flush,
    input  logic             ovf_clr,
    input  logic [AW-1:0]    rd_idx,
    output logic [31:0]      rd_word,
    output logic [LEN_W-1:0] head_len,
    output logic [PW-1:0]    fill_words,
    output logic             overflow
);
    localparam logic [PW-1:0] WORDS_C = PW'(WORDS);

    logic [31:0]   mem [WORDS];
    logic [PW-1:0] fill_q;
    logic          accept;
    logic          ovf_q;

    // A write lands only when no frame is in flight and a slot is free
    assign accept = wr_en && !lock && (fill_q < WORDS_C);

    // Word storage; contents need no reset since reads are gated by fill
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[fill_q[AW-1:0]] <= wr_data;
        end
    end

    // Append pointer: grows on each accepted word, cleared by a flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (flush) begin
            fill_q <= '0;
        end else if (accept) begin
            fill_q <= fill_q + PW'(1);
        end
    end

    // Sticky overflow: set by a dropped write, cleared by a frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (wr_en && !accept) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

    assign rd_word    = mem[rd_idx];
    assign head_len   = mem[0][LEN_W-1:0];
    assign fill_words = fill_q;
    assign overflow   = ovf_q;

    // R10: a write attempted during a frame is reported as overflow
    a_r10_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && lock |=> overflow)
        else $error("write during frame not flagged");

    // R10: the fill level cannot move while a frame is in flight, unless flushed
    a_r10_fill_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock && !flush |=> $stable(fill_q))
        else $error("store changed under a frame");

    // R2: an accepted word advances the fill level by exactly one
    a_r2_append: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !lock && !flush && (fill_q < WORDS_C) |=> fill_q == $past(fill_q) + PW'(1))
        else $error("append pointer did not advance");
endmodule

// File: rtl/txq_seq.sv
// Frame sequencer: latches the length on a start, resolves padding,
// counts bytes over the valid/ready handshake and signals completion.
// Assumes head_len is the stored prefix and stays stable while sending.
module txq_seq
    import txq_pkg::*;
#(
    parameter int MIN_FRAME = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_req,
    input  logic             pad_en,
    input  logic             have_data,
    input  logic [LEN_W-1:0] head_len,
    input  logic             m_ready,
    output logic             busy,
    output logic             start,
    output logic             flush,
    output logic [CW-1:0]    cnt,
    output logic [LEN_W-1:0] len_q,
    output logic             m_valid,
    output logic             m_last,
    output logic             frame_done
);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_FRAME);

    seq_state_t       state_q;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    total_q;
    logic [CW-1:0]    total_c;
    logic [LEN_W-1:0] len_r;
    logic             done_q;
    logic             take_last;

    // Frame size on the wire after the pad decision
    assign total_c = (pad_en && ({1'b0, head_len} < MIN_C)) ? MIN_C : {1'b0, head_len};

    // Start only from idle and only with something stored
    assign start = (state_q == ST_IDLE) && tx_req && have_data;

    assign m_valid   = (state_q == ST_SEND);
    assign m_last    = m_valid && (cnt_q == total_q - CW'(1));
    assign take_last = m_last && m_ready;
    assign flush     = take_last || (start && (total_c == '0));

    // Sequencer state, byte counter, latched length and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            total_q <= '0;
            len_r   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        len_r   <= head_len;
                        total_q <= total_c;
                        cnt_q   <= '0;
                        if (total_c == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_SEND;
                        end
                    end
                end
                ST_SEND: begin
                    if (m_ready) begin
                        cnt_q <= cnt_q + CW'(1);
                        if (take_last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q == ST_SEND);
    assign cnt        = cnt_q;
    assign len_q      = len_r;
    assign frame_done = done_q;

    // R4: a stalled byte keeps its position until taken
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(cnt_q))
        else $error("byte position moved during stall");

    // R9: completion follows the final handshake and drops busy
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_ready && m_last |=> frame_done && !busy)
        else $error("no done pulse after last byte");

    // R9: the done indication lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done)
        else $error("done pulse longer than one cycle");

    // R5: the end marker only accompanies an offered byte
    a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid)
        else $error("end marker without valid");

    // R7: a frame never ends before its stated length
    a_r7_not_short: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> (cnt_q + CW'(1) >= {1'b0, len_r}))
        else $error("frame ended before stated length");
endmodule

// File: rtl/txq_lane_pick.sv
// Byte selector: maps the byte counter to a word and lane of the store,
// and forces zero for padding or for positions never written.
// Assumes the 2-byte length prefix occupies stream bytes 0 and 1.
module txq_lane_pick
    import txq_pkg::*;
#(
    parameter  int DEPTH_BYTES = 2048,
    localparam int WORDS = DEPTH_BYTES / LANES,
    localparam int AW    = $clog2(WORDS),
    localparam int PW    = $clog2(WORDS + 1)
) (
    input  logic [CW-1:0]    cnt,
    input  logic [LEN_W-1:0] len_q,
    input  logic [PW-1:0]    fill_words,
    input  logic [31:0]      rd_word,
    output logic [AW-1:0]    rd_idx,
    output logic [7:0]       byte_out
);
    localparam int PSW = CW + 1;
    localparam int BW  = PW + 2;
    localparam int XW  = (PSW > BW) ? PSW : BW;

    logic [PSW-1:0] pos;
    logic [XW-1:0]  pos_x;
    logic [XW-1:0]  written_x;
    logic           in_payload;
    logic           in_data;
    logic [7:0]     lanes [LANES];

    // Split the fetched word into its byte lanes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = rd_word[8*g +: 8];
    end

    // Stream position skips over the two prefix bytes
    assign pos       = {1'b0, cnt} + PSW'(2);
    assign pos_x     = XW'(pos);
    assign written_x = XW'({fill_words, 2'b00});
    assign rd_idx    = pos[AW+1:2];

    // Zero unless the byte is payload and was actually written
    assign in_payload = ({1'b0, cnt} < {2'b00, len_q});
    assign in_data    = (pos_x < written_x);
    assign byte_out   = (in_payload && in_data) ? lanes[pos[1:0]] : 8'h00;
endmodule

// File: rtl/txq_framer.sv
// Transmit FIFO framer top: word store, sequencer and byte selector.
// Streams one length-prefixed frame per request to a byte MAC port.
// Assumes synchronous active-low reset held for at least one clock.
module txq_framer
    import txq_pkg::*;
#(
    parameter int DEPTH_BYTES = 2048,
    parameter int MIN_FRAME   = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        tx_req,
    input  logic        pad_en,
    output logic        busy,
    output logic        overflow,
    output logic        frame_done,
    output logic        m_valid,
    input  logic        m_ready,
    output logic [7:0]  m_data,
    output logic        m_last
);
    localparam int WORDS = DEPTH_BYTES / LANES;
    localparam int AW    = $clog2(WORDS);
    localparam int PW    = $clog2(WORDS + 1);

    logic             busy_w;
    logic             start_w;
    logic             flush_w;
    logic [CW-1:0]    cnt_w;
    logic [LEN_W-1:0] len_w;
    logic [LEN_W-1:0] head_len_w;
    logic [PW-1:0]    fill_w;
    logic [AW-1:0]    rd_idx_w;
    logic [31:0]      rd_word_w;
    logic             have_data_w;

    assign have_data_w = (fill_w != '0);

    txq_store #(.DEPTH_BYTES(DEPTH_BYTES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .lock       (busy_w),
        .flush      (flush_w),
        .ovf_clr    (start_w),
        .rd_idx     (rd_idx_w),
        .rd_word    (rd_word_w),
        .head_len   (head_len_w),
        .fill_words (fill_w),
        .overflow   (overflow)
    );

    txq_seq #(.MIN_FRAME(MIN_FRAME)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_req     (tx_req),
        .pad_en     (pad_en),
        .have_data  (have_data_w),
        .head_len   (head_len_w),
        .m_ready    (m_ready),
        .busy       (busy_w),
        .start      (start_w),
        .flush      (flush_w),
        .cnt        (cnt_w),
        .len_q      (len_w),
        .m_valid    (m_valid),
        .m_last     (m_last),
        .frame_done (frame_done)
    );

    txq_lane_pick #(.DEPTH_BYTES(DEPTH_BYTES)) u_pick (
        .cnt        (cnt_w),
        .len_q      (len_w),
        .fill_words (fill_w),
        .rd_word    (rd_word_w),
        .rd_idx     (rd_idx_w),
        .byte_out   (m_data)
    );

    assign busy = busy_w;

    // R6: bytes beyond the stated payload go out as zero
    a_r6_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && ({1'b0, cnt_w} >= {2'b00, len_w}) |-> m_data == 8'h00)
        else $error("padding byte not zero");

    // R3: a request with an empty store starts nothing
    a_r3_empty_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req && !busy_w && (fill_w == '0) |=> !busy && !frame_done)
        else $error("empty request started a frame");

    // R1: nothing is offered to the MAC while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_valid && !m_last)
        else $error("byte offered while idle");
endmodule

// File: tb/txq_framer_test.sv
`timescale 1ns/1ps
module txq_framer_test;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tx_req = 1'b0;
    logic        pad_en = 1'b0;
    logic        m_ready = 1'b0;
    logic        busy, overflow, frame_done, m_valid, m_last;
    logic [7:0]  m_data;

    int          vectors = 0;
    int          errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    txq_framer #(.DEPTH_BYTES(DEPTH), .MIN_FRAME(60)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_req(tx_req), .pad_en(pad_en), .busy(busy), .overflow(overflow),
        .frame_done(frame_done), .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data), .m_last(m_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pay(input int len, input int i);
        return 8'((len * 7 + i * 13 + 1) & 255);
    endfunction

    task automatic push_word(input logic [31:0] w);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2: pack length prefix, payload and filler lanes into words
    task automatic load_frame(input int len, input int limit, output int written);
        int nw;
        nw = (len + 2 + 3) / 4;
        if (limit >= 0 && limit < nw) nw = limit;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] word;
            for (int l = 0; l < 4; l++) begin
                int k;
                k = 4 * w + l;
                if (k == 0)            word[8*l +: 8] = 8'(len & 255);
                else if (k == 1)       word[8*l +: 8] = 8'((len >> 8) & 255);
                else if (k < len + 2)  word[8*l +: 8] = pay(len, k - 2);
                else                   word[8*l +: 8] = 8'hA5;
            end
            push_word(word);
        end
        written = 4 * nw;
    endtask

    task automatic run_frame(input int len, input bit pad, input int written, input bit poke);
        int  total, got, cyc;
        bit  done, stalled;
        logic [7:0] held, exp;
        total = (pad && len < 60) ? 60 : len;
        pad_en = pad;
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        pad_en = ~pad;  // R6: later changes must not matter
        chk(busy == (total > 0), "R9 busy after start", busy, total > 0);
        got = 0; cyc = 0; done = 0; stalled = 0; held = '0;
        while (!done && cyc < 400) begin
            if (frame_done) begin
                done = 1;
                chk(got == total, pad ? "R6 frame size" : "R7 frame size", got, total);
                chk(!busy, "R9 busy low at done", busy, 0);
                m_ready = 1'b0;
            end else begin
                if (poke && cyc == 2) begin
                    wr_en = 1'b1; wr_data = 32'hDEADBEEF; tx_req = 1'b1;  // R10, R3 probes
                end else begin
                    wr_en = 1'b0; tx_req = 1'b0;
                end
                if (m_valid) begin
                    if (stalled) chk(m_data == held, "R4 stall hold", m_data, held);
                    if (got < len) exp = (got + 2 < written) ? pay(len, got) : 8'h00;
                    else exp = 8'h00;
                    chk(m_data == exp, got >= len ? "R6 pad byte" :
                        (got + 2 >= written ? "R8 unwritten byte" : "R4 payload byte"), m_data, exp);
                    chk(m_last == (got == total - 1), "R5 end marker", m_last, got == total - 1);
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    m_ready = lfsr[0] | lfsr[1];
                    stalled = !m_ready;
                    held = m_data;
                    if (m_ready) got++;
                end else begin
                    m_ready = 1'b0;
                    chk(1'b0, "R9 gap inside frame", m_valid, 1);
                end
                @(negedge clk);
                cyc++;
            end
        end
        wr_en = 1'b0; tx_req = 1'b0;
        if (!done) chk(1'b0, "R9 frame never completed", got, total);
        if (poke) chk(overflow == 1'b1, "R10 write in frame flagged", overflow, 1);
        @(negedge clk);
        chk(!frame_done, "R9 done single cycle", frame_done, 0);
    endtask

    initial begin
        int wr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !overflow && !frame_done && !m_valid && !m_last, "R1 reset state",
            {busy, overflow, frame_done, m_valid, m_last}, 0);

        // R3: request with nothing stored
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        chk(!busy && !m_valid, "R3 empty request", busy, 0);
        @(negedge clk);
        chk(!frame_done, "R3 empty request no done", frame_done, 0);

        // Sweep every length that fits, padding off then on (R2, R4, R5, R6, R7)
        for (int p = 0; p < 2; p++) begin
            for (int len = 0; len <= DEPTH - 2; len++) begin
                load_frame(len, -1, wr);
                run_frame(len, p[0], wr, 1'b0);
            end
        end

        // R8: stated length longer than the data written
        load_frame(20, 2, wr);
        run_frame(20, 1'b0, wr, 1'b0);
        load_frame(10, 1, wr);
        run_frame(10, 1'b1, wr, 1'b0);

        // R10 and R3: write and request while a frame is in flight
        load_frame(30, -1, wr);
        run_frame(30, 1'b1, wr, 1'b1);
        chk(overflow, "R10 flag sticky", overflow, 1);
        load_frame(5, -1, wr);
        run_frame(5, 1'b0, wr, 1'b0);
        chk(!overflow, "R10 cleared by start", overflow, 0);

        // R10: write into a full store
        load_frame(DEPTH - 2, -1, wr);
        push_word(32'h11111111);
        chk(overflow, "R10 full store flagged", overflow, 1);
        run_frame(DEPTH - 2, 1'b0, wr, 1'b0);
        chk(!overflow, "R10 cleared after full", overflow, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule